// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block divides a fast source clock by a factor set at run time. The output high phase and low phase each come from their own 8-bit count, so one pair of settings fixes both the division ratio and the duty cycle. A bypass setting sends the source clock straight to the output. A half-cycle stretch setting lets the output fall on a falling edge of the source clock, which gives a duty cycle close to 50% for odd ratios.

Software or a controller places new settings on a parallel input bus and pulses an update strobe for one cycle. The settings are held in a shadow register. They move into the active set only at the start of the next output high phase. The output period that is running when the strobe arrives always finishes with the settings it started with, so no short pulse is produced. The reset is synchronous and active-high. It holds the output low and loads default counts that are set by parameters.

Top module: `hl_clk_divider`

## Requirements
- R1: With bypass and stretch both 0, each output period lasts `high + low` source cycles. The output is high for the first `high` of those cycles and low for the rest. Every output edge lines up with a rising source edge.
- R2: A count value of 0 on either the high or the low setting stands for 256 source cycles.
- R3: While bypass is active (`set_bypass` = 1 captured), `clk_out` equals `clk_in`: high for half a source cycle and low for half a source cycle.
- R4: While stretch is active (`set_odd` = 1 captured, bypass 0), the high phase lasts `high + 0.5` source cycles and the low phase lasts `low - 0.5` cycles. The falling output edge lines up with a falling source edge.
- R5: The setting inputs are captured only in a cycle where `upd_stb` is 1. Changes on those inputs while `upd_stb` is 0 have no effect on the output.
- R6: Captured settings take effect at the first rising output edge that comes strictly after the capturing clock edge. The period that is running when the strobe arrives completes with its old settings. Periods before and after the change are never shortened.
- R7: While `rst` is high, `clk_out` is low and the active settings are `RST_HIGH`/`RST_LOW` with bypass and stretch off. The first rising `clk_in` edge after reset is released starts an output high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Source clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | One-cycle strobe that captures the setting inputs |
| set_high | input | 8 | High-phase length in source cycles (0 means 256) |
| set_low | input | 8 | Low-phase length in source cycles (0 means 256) |
| set_bypass | input | 1 | 1 = output follows the source clock directly |
| set_odd | input | 1 | 1 = move the falling output edge half a cycle later |
| clk_out | output | 1 | Divided clock |

## Verification
A wrong phase counter value shows up as a high or low run of the wrong length within the same output period. A settings update latched at the wrong time changes the length of the period that was running when the strobe came, and this is visible one period after the strobe. The bench samples the output twice per source cycle and measures every high run and every low run in half-cycle units. A stuck or missing stretch flop therefore causes a mismatch of one half-cycle in the first stretched period.

// File: rtl/hldiv_pkg.sv
package hldiv_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned POS_W = CNT_W + 1;
  localparam int unsigned PER_W = CNT_W + 2;

  typedef struct packed {
    logic             bypass;
    logic             odd;
    logic [CNT_W-1:0] high;
    logic [CNT_W-1:0] low;
  } div_cfg_t;

  // A count of zero stands for the full 2**CNT_W cycles.
  function automatic logic [POS_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    logic [POS_W-1:0] r;
    if (c == '0) r = POS_W'(1) << CNT_W;
    else         r = POS_W'(c);
    return r;
  endfunction

  function automatic logic [PER_W-1:0] period_of(input div_cfg_t c);
    logic [PER_W-1:0] r;
    if (c.bypass) r = PER_W'(1);
    else          r = PER_W'(eff_count(c.high)) + PER_W'(eff_count(c.low));
    return r;
  endfunction
endpackage

// File: rtl/hl_cfg_shadow.sv
module hl_cfg_shadow
  import hldiv_pkg::*;
#(
  parameter div_cfg_t RST_CFG = '0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     upd,
  input  div_cfg_t new_cfg,
  input  logic     wrap,
  output div_cfg_t act
);
  div_cfg_t shadow;
  logic     pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= RST_CFG;
      pend   <= 1'b0;
      act    <= RST_CFG;
    end else begin
      if (upd) begin
        shadow <= new_cfg;
        pend   <= 1'b1;
      end else if (wrap) begin
        pend   <= 1'b0;
      end
      if (wrap && pend) act <= shadow;
    end
  end

  // R5: a strobe leaves a pending copy of the inputs
  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    upd |=> (pend && shadow == $past(new_cfg)));

  // R5: without a strobe the shadow copy does not move
  p_ignore_r5: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(shadow));

  // R6: active settings change only on a period boundary
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act));
endmodule

// File: rtl/hl_phase_counter.sv
module hl_phase_counter
  import hldiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  div_cfg_t act,
  output logic     wrap,
  output logic     hi_q
);
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] pos_nx;
  logic [POS_W-1:0] high_e;
  logic [PER_W-1:0] per;
  logic             first;

  always_comb begin
    per    = period_of(act);
    high_e = eff_count(act.high);
    pos_nx = pos + POS_W'(1);
    wrap   = first || ((PER_W'(pos) + PER_W'(1)) == per);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      first <= 1'b1;
      hi_q  <= 1'b0;
    end else if (wrap) begin
      pos   <= '0;
      first <= 1'b0;
      hi_q  <= 1'b1;
    end else begin
      pos   <= pos_nx;
      hi_q  <= (pos_nx < high_e);
    end
  end

  // R7: reset forces the high-phase flag low
  p_reset_low_r7: assert property (@(posedge clk)
    rst |=> !hi_q);

  // R1: the position never leaves the active period
  p_pos_bound_r1: assert property (@(posedge clk) disable iff (rst)
    !first |-> (PER_W'(pos) < per));

  // R1: the high phase ends exactly after the programmed count
  p_fall_at_high_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(hi_q) |-> (pos == high_e));

  // R6: a high phase only begins at position zero
  p_rise_on_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_q) |-> (pos == '0));
endmodule

// File: rtl/hl_half_stretch.sv
module hl_half_stretch (
  input  logic clk,
  input  logic rst,
  input  logic hi_q,
  output logic hi_n
);
  // Copy of the high-phase flag delayed to the falling source edge.
  always_ff @(negedge clk) begin
    if (rst) hi_n <= 1'b0;
    else     hi_n <= hi_q;
  end
endmodule

// File: rtl/hl_clk_divider.sv
module hl_clk_divider
  import hldiv_pkg::*;
#(
  parameter int unsigned RST_HIGH = 2,
  parameter int unsigned RST_LOW  = 2
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic             upd_stb,
  input  logic [CNT_W-1:0] set_high,
  input  logic [CNT_W-1:0] set_low,
  input  logic             set_bypass,
  input  logic             set_odd,
  output logic             clk_out
);
  localparam div_cfg_t RST_CFG = '{bypass: 1'b0, odd: 1'b0,
                                   high: CNT_W'(RST_HIGH), low: CNT_W'(RST_LOW)};

  div_cfg_t new_cfg;
  div_cfg_t act;
  logic     wrap;
  logic     hi_q;
  logic     hi_n;

  always_comb begin
    new_cfg.bypass = set_bypass;
    new_cfg.odd    = set_odd;
    new_cfg.high   = set_high;
    new_cfg.low    = set_low;
  end

  hl_cfg_shadow #(.RST_CFG(RST_CFG)) u_shadow (
    .clk(clk_in), .rst(rst), .upd(upd_stb), .new_cfg(new_cfg),
    .wrap(wrap), .act(act)
  );

  hl_phase_counter u_count (
    .clk(clk_in), .rst(rst), .act(act), .wrap(wrap), .hi_q(hi_q)
  );

  hl_half_stretch u_stretch (
    .clk(clk_in), .rst(rst), .hi_q(hi_q), .hi_n(hi_n)
  );

  always_comb begin
    if (act.bypass) clk_out = clk_in;
    else            clk_out = hi_q | (act.odd & hi_n);
  end

  // R4: with stretch off the delayed copy never shows at the output
  p_no_stretch_r4: assert property (@(posedge clk_in) disable iff (rst)
    (!act.bypass && !act.odd) |-> (clk_out == hi_q));
endmodule

// File: tb/sim_hl_clk_divider.sv
module sim_hl_clk_divider;
  import hldiv_pkg::*;

  typedef struct {
    int    hi;
    int    lo;
    int    cyc;
    string tag;
  } exp_t;

  logic clk_in = 1'b0;
  logic rst = 1'b1;
  logic upd_stb = 1'b0;
  logic [CNT_W-1:0] set_high = '0;
  logic [CNT_W-1:0] set_low = '0;
  logic set_bypass = 1'b0;
  logic set_odd = 1'b0;
  logic clk_out;

  always #2 clk_in = ~clk_in;

  hl_clk_divider u0 (
    .clk_in(clk_in), .rst(rst), .upd_stb(upd_stb), .set_high(set_high),
    .set_low(set_low), .set_bypass(set_bypass), .set_odd(set_odd),
    .clk_out(clk_out)
  );

  int   cyc = 0;
  int   nchk = 0;
  int   nfail = 0;
  int   rises = 0;
  exp_t q[$];
  exp_t cur;
  bit   prev = 1'b0;
  bit   in_period = 1'b0;
  int   run = 0;
  int   hrun = 0;

  always @(posedge clk_in) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: measures runs in half-cycle units.
  task automatic take(input bit s);
    if (rst) begin
      prev = 1'b0; in_period = 1'b0; run = 0;
      return;
    end
    if (s == prev) begin
      run++;
    end else begin
      if (s) begin
        if (in_period) begin
          check(hrun == cur.hi, cur.tag, "high half-cycles", hrun, cur.hi);
          check(run == cur.lo, cur.tag, "low half-cycles", run, cur.lo);
        end
        while (q.size() > 0 && q[0].cyc < cyc) cur = q.pop_front();
        in_period = 1'b1;
        rises++;
      end else begin
        hrun = run;
      end
      run = 1;
      prev = s;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_in); #1; take(clk_out);
      @(negedge clk_in); #1; take(clk_out);
    end
  end

  function automatic exp_t expect_of(input int h, input int l, input bit byp, input bit odd, input int c);
    exp_t e;
    int hh, ll;
    hh = (h == 0) ? 256 : h;
    ll = (l == 0) ? 256 : l;
    e.cyc = c;
    if (byp) begin
      e.hi = 1; e.lo = 1; e.tag = "R3";
    end else if (odd) begin
      e.hi = 2*hh + 1; e.lo = 2*ll - 1; e.tag = "R4";
    end else begin
      e.hi = 2*hh; e.lo = 2*ll;
      e.tag = (h == 0 || l == 0) ? "R2" : "R1";
    end
    if (odd && !byp && (h == 0 || l == 0)) e.tag = "R2";
    return e;
  endfunction

  // Driver: strobe a setting, push the expected widths, scramble the
  // inputs without a strobe (R5), then let nper periods run (R6).
  task automatic apply(input int h, input int l, input bit byp, input bit odd, input int nper);
    int r0;
    @(negedge clk_in);
    set_high = CNT_W'(h); set_low = CNT_W'(l);
    set_bypass = byp; set_odd = odd; upd_stb = 1'b1;
    @(posedge clk_in); #1;
    q.push_back(expect_of(h, l, byp, odd, cyc));
    @(negedge clk_in);
    upd_stb = 1'b0;
    set_high = CNT_W'($urandom_range(0, 255));
    set_low = CNT_W'($urandom_range(0, 255));
    set_bypass = 1'($urandom_range(0, 1));
    set_odd = 1'($urandom_range(0, 1));
    wait (q.size() == 0);
    r0 = rises;
    wait (rises >= r0 + nper + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_in);
    nfail++;
    $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 200000);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    exp_t e0;
    e0.hi = 4; e0.lo = 4; e0.cyc = 0; e0.tag = "R7";
    q.push_back(e0);
    repeat (2) @(posedge clk_in);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_in); #1;
      check(clk_out == 1'b0, "R7", "output in reset (rise)", int'(clk_out), 0);
      @(negedge clk_in); #1;
      check(clk_out == 1'b0, "R7", "output in reset (fall)", int'(clk_out), 0);
    end
    @(negedge clk_in);
    rst = 1'b0;
    @(posedge clk_in); #1;
    check(clk_out == 1'b1, "R7", "first edge after reset", int'(clk_out), 1);
    wait (q.size() == 0);
    begin
      int r0;
      r0 = rises;
      wait (rises >= r0 + 3);
    end

    apply(5, 5, 1'b0, 1'b0, 3);     // R1 even split
    apply(3, 2, 1'b0, 1'b0, 3);     // R1 uneven
    apply(1, 1, 1'b0, 1'b0, 4);     // R1 smallest
    apply(2, 3, 1'b0, 1'b1, 3);     // R4 2.5/2.5
    apply(1, 1, 1'b0, 1'b1, 3);     // R4 1.5/0.5
    apply(0, 1, 1'b0, 1'b0, 2);     // R2 high = 256
    apply(3, 0, 1'b0, 1'b1, 2);     // R2 low = 256 with stretch
    apply(4, 4, 1'b1, 1'b0, 6);     // R3 bypass
    apply(7, 2, 1'b0, 1'b1, 3);     // R6 leave bypass
    apply(9, 9, 1'b1, 1'b1, 5);     // R3 bypass overrides stretch
    for (int i = 0; i < 40; i++) begin
      apply($urandom_range(1, 24), $urandom_range(1, 24),
            ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)), 3);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule